// File: doc/BRIEF.md
# CAN Error Flag and Error Code Capture Registers

This block holds the error reporting state of a CAN controller. A protocol engine sends single-cycle event pulses, one wire per error condition. Each pulse sets a sticky bit in an 8-bit error flag register. An 8-bit enable register uses the same bit layout and selects which flags may raise an interrupt. A second group of pulses reports the kind of protocol error. These pulses are captured in an error code register. That register keeps a growing set of codes or only the most recent one, depending on a mode bit that software writes.

Software clears a flag or a code by writing a byte. Every bit written as 0 is cleared and every bit written as 1 is left unchanged, so one condition can be acknowledged by writing the complement of its mask. Any flag that is set together with its enable raises an error summary bit in the interrupt status register. That summary bit is gated by an interrupt enable bit to drive the interrupt output. The transmit and receive error counts come from the protocol engine and are passed through as read-only registers.

Registers are reached through a 3-bit select. Address 0 is the error flags, 1 the error enables, 2 the error code and mode, 3 the interrupt status, 4 the interrupt enable, 5 the transmit error count, 6 the receive error count, and 7 is unused.

Top module: `can_err_report`

## Requirements
- R1: After reset, the flag, enable, code, interrupt status and interrupt enable registers all read 0x00, and `irq_o` is low.
- R2: A pulse on `err_evt_i[i]` sets flag bit i from the next clock onward, and the bit stays set until software clears it. The flag bit order, from bit 7 down to bit 0, is: bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears exactly the flag bits written as 0 and leaves the bits written as 1 unchanged.
- R4: If an event pulse and a clearing write hit the same flag bit in one cycle, the bit ends up set.
- R5: The enable register at address 1 is fully readable and writable and uses the flag bit positions.
- R6: When bit 7 of the error code register (address 2) is 1, each pulse on `code_evt_i` is ORed into bits 6:0. The code bit order, from bit 6 down to bit 0, is: ACK delimiter, dominant bit error, recessive bit error, CRC, ACK, form, stuff.
- R7: When bit 7 of the error code register is 0, a code pulse replaces bits 6:0 with the new code, so all older codes are cleared.
- R8: A write to address 2 sets the mode bit to bit 7 of the written data and clears the code bits written as 0, keeping the code bits written as 1.
- R9: Bit 5 of the interrupt status register (address 3) is 1 exactly when some flag bit and its enable bit are both 1. All other status bits read 0.
- R10: Only bit 5 of the interrupt enable register (address 4) is stored, and the other bits read 0. `irq_o` is high exactly when status bit 5 and interrupt enable bit 5 are both 1.
- R11: Address 5 reads `tx_cnt_i` and address 6 reads `rx_cnt_i`.
- R12: Address 7 reads 0x00. Writes to addresses 3, 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 8 | Error event pulses, in the flag bit order |
| code_evt_i | input | 7 | Protocol error type pulses, in the code bit order |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register (combinational) |
| tx_cnt_i | input | 8 | Transmit error count from the protocol engine |
| rx_cnt_i | input | 8 | Receive error count from the protocol engine |
| irq_o | output | 1 | Error interrupt request |

## Verification
The flag register is driven from a vector table that mixes several kinds of step:
- pulses alone on single bits and on groups of bits, which separate setting from holding;
- all-ones writes, which show that a 1 leaves a bit alone;
- complement-mask writes, which show that a 0 clears only its own bit;
- a write and a pulse in the same cycle, both on different bits and on the same bit, which exposes the priority between event and clear.

The code register is driven with a second pulse in each capture mode, which separates replacement from accumulation. The status and interrupt paths are stepped through a sequence that enables the flag, the source and the output one at a time, so that a missing gate shows up.

// File: rtl/can_err_report.sv
module can_err_report (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] err_evt_i,
  input  logic [6:0] code_evt_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic [7:0] tx_cnt_i,
  input  logic [7:0] rx_cnt_i,
  output logic       irq_o
);
  localparam logic [2:0] A_FLAG = 3'd0;
  localparam logic [2:0] A_EN   = 3'd1;
  localparam logic [2:0] A_CODE = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_TXC  = 3'd5;
  localparam logic [2:0] A_RXC  = 3'd6;
  localparam int         SUM_BIT = 5;

  logic [7:0] flag_q, en_q;
  logic [6:0] code_q;
  logic       acc_q, ien_q;

  logic       wr_flag, wr_en, wr_code, wr_ien;
  logic [7:0] flag_kept;
  logic [6:0] code_kept;
  logic       summary;

  assign wr_flag = wr_en_i && addr_i == A_FLAG;
  assign wr_en   = wr_en_i && addr_i == A_EN;
  assign wr_code = wr_en_i && addr_i == A_CODE;
  assign wr_ien  = wr_en_i && addr_i == A_IEN;

  assign flag_kept = wr_flag ? (flag_q & wr_data_i) : flag_q;
  assign code_kept = wr_code ? (code_q & wr_data_i[6:0]) : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      code_q <= '0;
      acc_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      flag_q <= flag_kept | err_evt_i;
      if (wr_en)   en_q  <= wr_data_i;
      if (wr_code) acc_q <= wr_data_i[7];
      if (wr_ien)  ien_q <= wr_data_i[SUM_BIT];
      if (code_evt_i == '0)
        code_q <= code_kept;
      else if (acc_q)
        code_q <= code_kept | code_evt_i;
      else
        code_q <= code_evt_i;
    end
  end

  assign summary = |(flag_q & en_q);
  assign irq_o   = summary & ien_q;

  always_comb begin
    unique case (addr_i)
      A_FLAG:  rd_data_o = flag_q;
      A_EN:    rd_data_o = en_q;
      A_CODE:  rd_data_o = {acc_q, code_q};
      A_STAT:  rd_data_o = 8'(summary) << SUM_BIT;
      A_IEN:   rd_data_o = 8'(ien_q) << SUM_BIT;
      A_TXC:   rd_data_o = tx_cnt_i;
      A_RXC:   rd_data_o = rx_cnt_i;
      default: rd_data_o = 8'h00;
    endcase
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt_i != 8'h00) |=> ((flag_q & $past(err_evt_i)) == $past(err_evt_i))); // R4

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(err_evt_i)) == 8'h00)); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R3

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != 8'h00 && en_q != 8'h00)); // R10

  AST_LATEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q && code_evt_i != 7'h00) |=> (code_q == $past(code_evt_i))); // R7

  AST_ACCUM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !(wr_en_i && addr_i == A_CODE)) |=> ((code_q & $past(code_q)) == $past(code_q))); // R6
endmodule

// File: tb/can_err_report_tb.sv
module can_err_report_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] err_evt_i = '0;
  logic [6:0] code_evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [7:0] tx_cnt_i = '0;
  logic [7:0] rx_cnt_i = '0;
  logic       irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  can_err_report dut_i (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i), .code_evt_i(code_evt_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .tx_cnt_i(tx_cnt_i), .rx_cnt_i(rx_cnt_i), .irq_o(irq_o)
  );

  // vector: {event[7:0], write, write data[7:0], expected flags[7:0]}, all on address 0
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {8'h01, 1'b0, 8'h00, 8'h01},
    {8'h80, 1'b0, 8'h00, 8'h81},
    {8'h24, 1'b0, 8'h00, 8'hA5},
    {8'h00, 1'b1, 8'hFE, 8'hA4},
    {8'h00, 1'b1, 8'hFF, 8'hA4},
    {8'h08, 1'b1, 8'h7F, 8'h2C},
    {8'h04, 1'b1, 8'hFB, 8'h2C},
    {8'h00, 1'b1, 8'h00, 8'h00}
  };

  task automatic check(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr_i = a;
    #1;
    tests++;
    if (rd_data_o !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rd_data_o, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string req);
    #1;
    tests++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s irq: got %0b expected %0b", req, irq_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; err_evt_i = '0; code_evt_i = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    step();
  endtask

  task automatic code_pulse(input logic [6:0] c);
    code_evt_i = c;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(3'd0, 8'h00, "R1");
    check(3'd1, 8'h00, "R1");
    check(3'd2, 8'h00, "R1");
    check(3'd3, 8'h00, "R1");
    check(3'd4, 8'h00, "R1");
    check_irq(1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 flag vectors
    for (int i = 0; i < NV; i++) begin
      addr_i = 3'd0;
      err_evt_i = VEC[i][24:17];
      wr_en_i = VEC[i][16];
      wr_data_i = VEC[i][15:8];
      step();
      check(3'd0, VEC[i][7:0], (i == 6) ? "R4" : (i < 3) ? "R2" : "R3");
    end

    // R5 enable register
    wr(3'd1, 8'h5A);
    check(3'd1, 8'h5A, "R5");
    wr(3'd1, 8'h02);
    check(3'd1, 8'h02, "R5");

    // R9 R10 summary and interrupt
    err_evt_i = 8'h01;
    step();
    check(3'd3, 8'h00, "R9");
    err_evt_i = 8'h02;
    step();
    check(3'd3, 8'h20, "R9");
    check_irq(1'b0, "R10");
    wr(3'd4, 8'hFF);
    check(3'd4, 8'h20, "R10");
    check_irq(1'b1, "R10");
    // R12 writes to read-only and unused addresses
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h00);
    check(3'd3, 8'h20, "R12");
    check(3'd0, 8'h03, "R12");
    check(3'd7, 8'h00, "R12");
    wr(3'd0, 8'hFD);
    check(3'd3, 8'h00, "R9");
    check_irq(1'b0, "R10");
    wr(3'd4, 8'hDF);
    check(3'd4, 8'h00, "R10");

    // R7 latest-only mode
    code_pulse(7'h08);
    check(3'd2, 8'h08, "R7");
    code_pulse(7'h02);
    check(3'd2, 8'h02, "R7");
    // R8 R6 accumulate mode
    wr(3'd2, 8'h80);
    check(3'd2, 8'h80, "R8");
    code_pulse(7'h10);
    code_pulse(7'h01);
    check(3'd2, 8'h91, "R6");
    wr(3'd2, 8'hFE);
    check(3'd2, 8'h90, "R8");
    wr(3'd2, 8'h7F);
    check(3'd2, 8'h10, "R8");
    code_pulse(7'h40);
    check(3'd2, 8'h40, "R7");

    // R11 counters
    tx_cnt_i = 8'h5A; rx_cnt_i = 8'hC3;
    check(3'd5, 8'h5A, "R11");
    check(3'd6, 8'hC3, "R11");
    tx_cnt_i = 8'hFF;
    check(3'd5, 8'hFF, "R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule